// File: doc/BRIEF.md
# Programmable Vertical Sync Pulse Generator

This block places one pulse per frame inside the vertical non-display period. Time is counted in display lines. A one-cycle strobe marks the first line of that period. From then on, a line strobe advances an internal line index. The pulse drives either the CRT vertical sync output or the flat-panel frame output, depending on which panel type is selected.

Four programmed fields shape the pulse: a 6-bit start delay, a 3-bit width, a 6-bit non-display length and two polarity bits. For passive panels the pulse is generated automatically, and the delay and width fields are not used. All settings are captured only when the start-of-non-display strobe arrives. A flag reports when the programmed length is too short to hold the requested pulse.

Top module: `vsync_gen`

## Requirements
- R1: Line index 0 is the line on which `vnd_start` is accepted. Each later `line_stb` advances the index by one, and `vnd_start` takes priority over `line_stb`. In CRT or TFT mode the pulse is active on lines S+1 through S+W+1, where S is the start field (0..63) and W is the width field (0..7). The pulse is therefore 1 to 8 lines long.
- R2: `panel_mode` encoding is 2'b00 = CRT, 2'b01 = TFT, and 2'b10 or 2'b11 = passive. `vsync_o` can be active only in CRT mode. `frame_o` can be active only in TFT or passive mode.
- R3: `vsync_o` shows the pulse at level `crt_pol` and rests at the opposite level.
- R4: In TFT mode `frame_o` shows the pulse at level `frm_pol`. In passive mode it shows the pulse at level `~frm_pol`. In CRT mode `frame_o` rests at `~frm_pol`.
- R5: In passive mode `frame_o` is active on line 0 only, whatever the start and width fields hold.
- R6: Let N be the length field. `cfg_err` is 1 when the mode is not passive and N+1 < (S+1)+(W+1). Otherwise it is 0. The error check looks only at the settings captured at the latest `vnd_start`.
- R7: The pulse is never active on a line index above N. This cuts the pulse off at the end of the non-display period.
- R8: All inputs other than the strobes are captured only in the cycle where `vnd_start` is 1. A change between two `vnd_start` strobes has no effect on the outputs.
- R9: After reset, and until the first `vnd_start`, `vsync_o` = 1, `frame_o` = 1 and `cfg_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_stb | input | 1 | Advances the line index by one |
| vnd_start | input | 1 | Marks the first line of vertical non-display and captures settings |
| panel_mode | input | 2 | 00 CRT, 01 TFT, 1x passive |
| start_dly | input | 6 | Start delay field S |
| pulse_wid | input | 3 | Width field W |
| vnd_len | input | 6 | Non-display length field N |
| crt_pol | input | 1 | Active level of the CRT sync |
| frm_pol | input | 1 | Frame polarity bit |
| vsync_o | output | 1 | CRT vertical sync |
| frame_o | output | 1 | Panel frame pulse |
| cfg_err | output | 1 | The programmed length cannot hold the pulse |

## Verification
In CRT mode the bench runs every start and width pair, with a long period and with a short period. The long period separates the pulse placement from the cut-off rule. The short period exercises the error flag and the truncation of the pulse. TFT and passive frames repeat the sweep with every polarity pair. These frames tell the two meanings of the frame polarity apart, and they show that passive mode ignores the start and width fields. Within every frame the settings inputs are changed at random, which exposes any capture outside the start strobe.

// File: rtl/vsync_gen.sv
module vsync_gen #(
  parameter int SW = 6,
  parameter int WW = 3,
  parameter int LW = 6,
  localparam int CW = (SW > LW ? SW : LW) + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_stb,
  input  logic          vnd_start,
  input  logic [1:0]    panel_mode,
  input  logic [SW-1:0] start_dly,
  input  logic [WW-1:0] pulse_wid,
  input  logic [LW-1:0] vnd_len,
  input  logic          crt_pol,
  input  logic          frm_pol,
  output logic          vsync_o,
  output logic          frame_o,
  output logic          cfg_err
);
  localparam logic [CW-1:0] SAT = '1;

  logic [CW-1:0] idx;
  logic          run;
  logic [1:0]    mode_q;
  logic [SW-1:0] st_q;
  logic [WW-1:0] wd_q;
  logic [LW-1:0] ln_q;
  logic          cp_q, fp_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      idx <= '0; run <= 1'b0; mode_q <= 2'b00;
      st_q <= '0; wd_q <= '0; ln_q <= '0;
      cp_q <= 1'b0; fp_q <= 1'b0;
    end else if (vnd_start) begin
      idx <= '0; run <= 1'b1; mode_q <= panel_mode;
      st_q <= start_dly; wd_q <= pulse_wid; ln_q <= vnd_len;
      cp_q <= crt_pol; fp_q <= frm_pol;
    end else if (line_stb && idx != SAT) begin
      idx <= idx + 1'b1;
    end

  wire          passive = mode_q[1];
  wire          tft     = !mode_q[1] && mode_q[0];
  wire          crt     = mode_q == 2'b00;
  wire [CW-1:0] first   = CW'(st_q) + 1'b1;
  wire [CW-1:0] last    = CW'(st_q) + CW'(wd_q) + 1'b1;
  wire          in_vnd  = idx <= CW'(ln_q);
  wire          act_pr  = run && in_vnd && idx >= first && idx <= last;
  wire          act_pv  = run && idx == '0;
  wire          act     = passive ? act_pv : act_pr;

  assign vsync_o = (crt && act) ? cp_q : ~cp_q;
  assign frame_o = passive ? (act ? ~fp_q : fp_q)
                           : ((tft && act) ? fp_q : ~fp_q);
  assign cfg_err = run && !passive && (CW'(ln_q) + 1'b1 < last + 1'b1);

  // R7
  pulse_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> idx <= CW'(ln_q));
  // R9
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (vsync_o && frame_o && !cfg_err));
  // R5
  passive_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (passive && act) |-> idx == '0);
  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vnd_start |=> ($stable(st_q) && $stable(wd_q) && $stable(ln_q) && $stable(mode_q)));
  // R1
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !vnd_start && !line_stb) |=> act);
endmodule

// File: tb/vsync_gen_test.sv
module vsync_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_stb = 1'b0, vnd_start = 1'b0;
  logic [1:0] panel_mode = 2'b00;
  logic [5:0] start_dly = '0;
  logic [2:0] pulse_wid = '0;
  logic [5:0] vnd_len = '0;
  logic crt_pol = 1'b0, frm_pol = 1'b0;
  logic vsync_o, frame_o, cfg_err;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vsync_gen uut (.clk(clk), .rst_n(rst_n), .line_stb(line_stb), .vnd_start(vnd_start),
    .panel_mode(panel_mode), .start_dly(start_dly), .pulse_wid(pulse_wid),
    .vnd_len(vnd_len), .crt_pol(crt_pol), .frm_pol(frm_pol),
    .vsync_o(vsync_o), .frame_o(frame_o), .cfg_err(cfg_err));

  task automatic chk(input string tag, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: {vsync,frame,err} got %b expected %b", tag, got, exp);
    end
  endtask

  // R1 R2 R3 R4 R5 R6 R7 R8
  task automatic frame(input logic [1:0] m, input int s, input int w, input int n,
                       input logic cp, input logic fp);
    bit act, ev, ef, ee;
    string tag;
    @(negedge clk);
    panel_mode = m; start_dly = 6'(s); pulse_wid = 3'(w); vnd_len = 6'(n);
    crt_pol = cp; frm_pol = fp; vnd_start = 1'b1;
    @(negedge clk);
    vnd_start = 1'b0;
    panel_mode = 2'($urandom); start_dly = 6'($urandom); pulse_wid = 3'($urandom);
    vnd_len = 6'($urandom); crt_pol = 1'($urandom); frm_pol = 1'($urandom);
    ee = (m[1] == 1'b0) && (n + 1 < s + w + 2);
    for (int i = 0; i <= n + 3; i++) begin
      if (i > 0) begin
        line_stb = 1'b1;
        @(negedge clk);
        line_stb = 1'b0;
      end
      if (m[1]) act = (i == 0);
      else act = (i >= s + 1) && (i <= s + w + 1) && (i <= n);
      ev = (m == 2'b00 && act) ? cp : ~cp;
      if (m[1]) ef = act ? ~fp : fp;
      else ef = (m == 2'b01 && act) ? fp : ~fp;
      if (m[1]) tag = "R5 R4 R8";
      else if (ee) tag = "R6 R7 R1 R8";
      else if (m == 2'b00) tag = "R1 R3 R2 R8";
      else tag = "R1 R4 R2 R8";
      chk(tag, {vsync_o, frame_o, cfg_err}, {ev, ef, ee});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9", {vsync_o, frame_o, cfg_err}, 3'b110);
    rst_n = 1'b1;
    repeat (2) begin
      line_stb = 1'b1; @(negedge clk); line_stb = 1'b0; @(negedge clk);
    end
    chk("R9", {vsync_o, frame_o, cfg_err}, 3'b110);
    for (int s = 0; s < 64; s++)
      for (int w = 0; w < 8; w++)
        frame(2'b00, s, w, 63, 1'(s), 1'(w));
    for (int s = 0; s < 64; s += 3)
      for (int w = 0; w < 8; w++)
        frame(2'b00, s, w, 12, 1'(w), 1'b0);
    for (int p = 0; p < 4; p++)
      for (int s = 0; s < 64; s += 7)
        for (int w = 0; w < 8; w++) begin
          frame(2'b01, s, w, (s * 5 + w) % 64, 1'(p), 1'(p >> 1));
          frame({1'b1, 1'(w)}, s, w, (s + w) % 64, 1'(p), 1'(p >> 1));
        end
    frame(2'b10, 63, 7, 0, 1'b0, 1'b1);
    frame(2'b01, 62, 0, 63, 1'b1, 1'b1);
    frame(2'b01, 62, 1, 63, 1'b1, 1'b0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule